// File: doc/BRIEF.md
# I2C Byte FIFO Pair with Trigger Interrupts

This block sits between a host register interface and an I2C transfer sequencer. It holds two byte queues. The host fills the transmit queue and the sequencer drains it. The sequencer fills the receive queue and the host drains it. Each queue has its own enable and its own programmable trigger level. The block also keeps a write-1-to-clear interrupt status register, masked by an enable vector, and one combined interrupt line.

The host uses the trigger levels to batch its work. A transmit request asks for more bytes while the transmit queue runs low. A receive request asks for a burst read once enough bytes have arrived. Some bytes can be left in the receive queue below the trigger level at the end of a transfer. A trailing timer raises its own request for these after a programmable number of quiet cycles. Overrun and underrun on either queue are recorded as sticky error bits. The queue depth is a parameter; 16 and 64 are the intended values.

Top module: `i2cfifo_pair`

## Requirements
- R1: Bytes pushed on the host transmit port leave on the sequencer transmit port in the same order. The pop data is valid the cycle after the pop. `fifo_status` reports the transmit level in bits 6:0, transmit full in bit 7 and transmit empty in bit 8.
- R2: Bytes pushed on the sequencer receive port leave on the host receive port in the same order. The pop data is valid the cycle after the pop. `fifo_status` reports the receive level in bits 22:16, receive full in bit 23 and receive empty in bit 24.
- R3: A push into a full queue is dropped and leaves the stored bytes unchanged. It sets `int_status` bit 3 for the transmit queue and bit 5 for the receive queue.
- R4: A pop from an empty queue returns 0x00. It sets `int_status` bit 2 for the transmit queue and bit 4 for the receive queue.
- R5: `ctrl_word` bit 0 enables the receive queue and bit 1 enables the transmit queue. While a queue is disabled it is held empty. Its pushes and pops are ignored and set no status bits. Its trigger bit and, for the receive queue, the trailing bit are not set.
- R6: `int_status` bit 0 is set on every cycle in which the transmit queue is enabled and its level is at or below the 7-bit trigger in `ctrl_word[22:16]`.
- R7: `int_status` bit 1 is set on every cycle in which the receive queue is enabled and its level is at or above the 7-bit trigger in `ctrl_word[10:4]`.
- R8: `int_status` bit 6 is set once the receive queue has held between one byte and one byte below its trigger for `trail_limit`+1 consecutive clock edges with no receive push or pop. Any receive push or pop restarts the count.
- R9: A write on `stat_clr_wr` clears exactly the `int_status` bits that are 1 in `stat_clr_mask` and leaves the others. A bit whose set condition holds in the same cycle stays set.
- R10: `irq` is high exactly when some `int_status` bit is set while the same bit of `int_mask` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_word | input | 32 | Queue enables and trigger levels |
| int_mask | input | 7 | Interrupt enable per status bit |
| trail_limit | input | TRAIL_W | Trailing idle count |
| host_tx_wr | input | 1 | Host push into transmit queue |
| host_tx_data | input | 8 | Byte to push into transmit queue |
| host_rx_rd | input | 1 | Host pop from receive queue |
| host_rx_data | output | 8 | Byte popped from receive queue |
| seq_tx_rd | input | 1 | Sequencer pop from transmit queue |
| seq_tx_data | output | 8 | Byte popped from transmit queue |
| seq_rx_wr | input | 1 | Sequencer push into receive queue |
| seq_rx_data | input | 8 | Byte to push into receive queue |
| stat_clr_wr | input | 1 | Status clear strobe |
| stat_clr_mask | input | 7 | Bits to clear in the status |
| fifo_status | output | 32 | Packed levels and full/empty flags |
| int_status | output | 7 | Sticky interrupt status |
| irq | output | 1 | Combined masked interrupt |

## Verification
The hardest case to reach is the trailing timer's exact firing edge and its restart. The status bit must be cleared without the clear itself landing on the firing edge. So the bench merges the clear with the last receive push, which resets the count. It then counts quiet edges and samples one edge before and one edge at the expected firing point. A merged pop and clear repeats this to show that activity restarts the count. The overrun and underrun paths are reached by filling each queue to the parameter depth and pushing or popping one past the limit.

// File: rtl/i2cfifo_pkg.sv
package i2cfifo_pkg;
  localparam int IST_W    = 7;
  localparam int LVL_W    = 7;
  localparam int TRIG_W   = 7;
  localparam int BYTE_W   = 8;

  // control word fields
  localparam int CF_RX_EN   = 0;
  localparam int CF_TX_EN   = 1;
  localparam int CF_RX_TRIG = 4;
  localparam int CF_TX_TRIG = 16;

  // interrupt status positions
  localparam int IS_TX_LOW   = 0;
  localparam int IS_RX_HIGH  = 1;
  localparam int IS_TX_UDF   = 2;
  localparam int IS_TX_OVF   = 3;
  localparam int IS_RX_UDF   = 4;
  localparam int IS_RX_OVF   = 5;
  localparam int IS_TRAIL    = 6;

  // packed status word positions
  localparam int ST_TX_LVL   = 0;
  localparam int ST_TX_FULL  = 7;
  localparam int ST_TX_EMPTY = 8;
  localparam int ST_RX_LVL   = 16;
  localparam int ST_RX_FULL  = 23;
  localparam int ST_RX_EMPTY = 24;

  typedef struct packed {
    logic ovf;
    logic udf;
  } q_evt_t;
endpackage

// File: rtl/i2cfifo_buf.sv
module i2cfifo_buf
  import i2cfifo_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              push,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              pop,
  output logic [BYTE_W-1:0] rdata,
  output logic [LVL_W-1:0]  level,
  output logic              full,
  output logic              empty,
  output q_evt_t            evt
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] CMAX = CW'(DEPTH);

  logic [BYTE_W-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic push_ok, pop_ok;

  assign full    = (cnt == CMAX);
  assign empty   = (cnt == '0);
  assign push_ok = en && push && !full;
  assign pop_ok  = en && pop && !empty;
  assign evt.ovf = en && push && full;
  assign evt.udf = en && pop && empty;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push_ok) wp <= (wp == LAST) ? '0 : wp + 1'b1;
      if (pop_ok)  rp <= (rp == LAST) ? '0 : rp + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // storage without reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)
      rdata <= '0;
    else if (pop_ok)
      rdata <= mem[rp];
    else if (evt.udf)
      rdata <= '0;
  end

  generate
    if (CW < LVL_W) begin : g_pad
      assign level = {{(LVL_W - CW){1'b0}}, cnt};
    end else begin : g_fit
      assign level = cnt[LVL_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/i2cfifo_trail.sv
module i2cfifo_trail
  import i2cfifo_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [LVL_W-1:0]  level,
  input  logic [TRIG_W-1:0] trig,
  input  logic              activity,
  input  logic [CNT_W-1:0]  limit,
  output logic              fire
);
  logic [CNT_W-1:0] cnt;
  logic quiet;

  assign quiet = en && (level != '0) && (level < trig) && !activity;
  assign fire  = quiet && (cnt == limit);

  always_ff @(posedge clk) begin
    if (rst || !quiet)
      cnt <= '0;
    else if (cnt != limit)
      cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/i2cfifo_istat.sv
module i2cfifo_istat
  import i2cfifo_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [IST_W-1:0] set_vec,
  input  logic             clr_wr,
  input  logic [IST_W-1:0] clr_mask,
  input  logic [IST_W-1:0] en_mask,
  output logic [IST_W-1:0] stat,
  output logic             irq
);
  logic [IST_W-1:0] clr_eff;

  assign clr_eff = clr_wr ? clr_mask : '0;

  always_ff @(posedge clk) begin
    if (rst)
      stat <= '0;
    else
      stat <= (stat & ~clr_eff) | set_vec;
  end

  assign irq = |(stat & en_mask);
endmodule

// File: rtl/i2cfifo_pair.sv
module i2cfifo_pair
  import i2cfifo_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int TRAIL_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [31:0]        ctrl_word,
  input  logic [6:0]         int_mask,
  input  logic [TRAIL_W-1:0] trail_limit,
  input  logic               host_tx_wr,
  input  logic [7:0]         host_tx_data,
  input  logic               host_rx_rd,
  output logic [7:0]         host_rx_data,
  input  logic               seq_tx_rd,
  output logic [7:0]         seq_tx_data,
  input  logic               seq_rx_wr,
  input  logic [7:0]         seq_rx_data,
  input  logic               stat_clr_wr,
  input  logic [6:0]         stat_clr_mask,
  output logic [31:0]        fifo_status,
  output logic [6:0]         int_status,
  output logic               irq
);
  logic tx_en, rx_en;
  logic [TRIG_W-1:0] tx_trig, rx_trig;
  logic [LVL_W-1:0] tx_lvl, rx_lvl;
  logic tx_full, tx_empty, rx_full, rx_empty;
  q_evt_t tx_evt, rx_evt;
  logic trail_fire;
  logic [IST_W-1:0] set_vec;

  assign rx_en   = ctrl_word[CF_RX_EN];
  assign tx_en   = ctrl_word[CF_TX_EN];
  assign rx_trig = ctrl_word[CF_RX_TRIG +: TRIG_W];
  assign tx_trig = ctrl_word[CF_TX_TRIG +: TRIG_W];

  i2cfifo_buf #(.DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst(rst), .en(tx_en),
    .push(host_tx_wr), .wdata(host_tx_data),
    .pop(seq_tx_rd), .rdata(seq_tx_data),
    .level(tx_lvl), .full(tx_full), .empty(tx_empty), .evt(tx_evt)
  );

  i2cfifo_buf #(.DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .en(rx_en),
    .push(seq_rx_wr), .wdata(seq_rx_data),
    .pop(host_rx_rd), .rdata(host_rx_data),
    .level(rx_lvl), .full(rx_full), .empty(rx_empty), .evt(rx_evt)
  );

  i2cfifo_trail #(.CNT_W(TRAIL_W)) u_trail (
    .clk(clk), .rst(rst), .en(rx_en),
    .level(rx_lvl), .trig(rx_trig),
    .activity(seq_rx_wr || host_rx_rd),
    .limit(trail_limit), .fire(trail_fire)
  );

  always_comb begin
    set_vec              = '0;
    set_vec[IS_TX_LOW]   = tx_en && (tx_lvl <= tx_trig);
    set_vec[IS_RX_HIGH]  = rx_en && (rx_lvl >= rx_trig);
    set_vec[IS_TX_UDF]   = tx_evt.udf;
    set_vec[IS_TX_OVF]   = tx_evt.ovf;
    set_vec[IS_RX_UDF]   = rx_evt.udf;
    set_vec[IS_RX_OVF]   = rx_evt.ovf;
    set_vec[IS_TRAIL]    = trail_fire;
  end

  i2cfifo_istat u_ist (
    .clk(clk), .rst(rst), .set_vec(set_vec),
    .clr_wr(stat_clr_wr), .clr_mask(stat_clr_mask),
    .en_mask(int_mask), .stat(int_status), .irq(irq)
  );

  always_comb begin
    fifo_status                         = '0;
    fifo_status[ST_TX_LVL +: LVL_W]     = tx_lvl;
    fifo_status[ST_TX_FULL]             = tx_full;
    fifo_status[ST_TX_EMPTY]            = tx_empty;
    fifo_status[ST_RX_LVL +: LVL_W]     = rx_lvl;
    fifo_status[ST_RX_FULL]             = rx_full;
    fifo_status[ST_RX_EMPTY]            = rx_empty;
  end
endmodule

// File: rtl/i2cfifo_pair_chk.sv
module i2cfifo_pair_chk #(
  parameter int DEPTH = 16
) (
  input logic        clk,
  input logic        rst,
  input logic [31:0] ctrl_word,
  input logic [6:0]  int_mask,
  input logic        host_tx_wr,
  input logic        host_rx_rd,
  input logic [31:0] fifo_status,
  input logic [6:0]  int_status,
  input logic        irq
);
  p_tx_level_bound_r1: assert property (@(posedge clk) disable iff (rst)
    fifo_status[6:0] <= 7'(DEPTH));

  p_rx_flags_excl_r2: assert property (@(posedge clk) disable iff (rst)
    !(fifo_status[23] && fifo_status[24]));

  p_tx_overrun_r3: assert property (@(posedge clk) disable iff (rst)
    (ctrl_word[1] && host_tx_wr && fifo_status[7]) |=> int_status[3]);

  p_rx_underrun_r4: assert property (@(posedge clk) disable iff (rst)
    (ctrl_word[0] && host_rx_rd && fifo_status[24]) |=> int_status[4]);

  p_rx_off_empty_r5: assert property (@(posedge clk) disable iff (rst)
    !ctrl_word[0] |=> (fifo_status[22:16] == 7'd0));

  p_masked_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    (int_mask == 7'd0) |-> !irq);
endmodule

bind i2cfifo_pair i2cfifo_pair_chk #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst(rst), .ctrl_word(ctrl_word), .int_mask(int_mask),
  .host_tx_wr(host_tx_wr), .host_rx_rd(host_rx_rd),
  .fifo_status(fifo_status), .int_status(int_status), .irq(irq)
);

// File: tb/i2cfifo_pair_tb.sv
`timescale 1ns/1ps
module i2cfifo_pair_tb_top;
  localparam int DEPTH = 16;
  localparam logic [31:0] CTRL_ON = 32'h3 | (32'd4 << 4) | (32'd2 << 16);
  localparam logic [31:0] CTRL_TXOFF = 32'h1 | (32'd4 << 4) | (32'd2 << 16);

  // op[9:8]: 0 host tx push, 1 seq tx pop (expect), 2 seq rx push, 3 host rx pop (expect)
  localparam logic [9:0] VEC [12] = '{
    {2'd0, 8'hA1}, {2'd0, 8'hA2}, {2'd0, 8'hA3}, {2'd1, 8'hA1},
    {2'd0, 8'hA4}, {2'd1, 8'hA2}, {2'd1, 8'hA3}, {2'd1, 8'hA4},
    {2'd2, 8'h5C}, {2'd2, 8'h6D}, {2'd3, 8'h5C}, {2'd3, 8'h6D}
  };

  logic clk = 0, rst = 1;
  logic [31:0] ctrl_word = '0;
  logic [6:0]  int_mask = '0;
  logic [3:0]  trail_limit = '0;
  logic host_tx_wr = 0, host_rx_rd = 0, seq_tx_rd = 0, seq_rx_wr = 0;
  logic [7:0] host_tx_data = '0, seq_rx_data = '0;
  logic stat_clr_wr = 0;
  logic [6:0] stat_clr_mask = '0;
  logic [7:0] host_rx_data, seq_tx_data;
  logic [31:0] fifo_status;
  logic [6:0] int_status;
  logic irq;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  i2cfifo_pair #(.DEPTH(DEPTH), .TRAIL_W(4)) dut_i (.*);

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tx_push(logic [7:0] d);
    host_tx_wr = 1; host_tx_data = d; cyc(); host_tx_wr = 0;
  endtask
  task automatic tx_pop();
    seq_tx_rd = 1; cyc(); seq_tx_rd = 0;
  endtask
  task automatic rx_push(logic [7:0] d);
    seq_rx_wr = 1; seq_rx_data = d; cyc(); seq_rx_wr = 0;
  endtask
  task automatic rx_pop();
    host_rx_rd = 1; cyc(); host_rx_rd = 0;
  endtask
  task automatic clr(logic [6:0] m);
    stat_clr_wr = 1; stat_clr_mask = m; cyc(); stat_clr_wr = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic ok;
    repeat (3) cyc();
    rst = 0;
    chk("R1 R2 reset status", fifo_status, 32'h0100_0100);
    chk("R9 reset int_status", {25'd0, int_status}, 32'd0);
    chk("R10 reset irq", {31'd0, irq}, 32'd0);

    ctrl_word = CTRL_ON; trail_limit = 4'd3;
    cyc();

    // vector table walk
    for (int i = 0; i < 12; i++) begin
      case (VEC[i][9:8])
        2'd0: tx_push(VEC[i][7:0]);
        2'd1: begin tx_pop(); chk("R1 tx order", {24'd0, seq_tx_data}, {24'd0, VEC[i][7:0]}); end
        2'd2: rx_push(VEC[i][7:0]);
        default: begin rx_pop(); chk("R2 rx order", {24'd0, host_rx_data}, {24'd0, VEC[i][7:0]}); end
      endcase
    end

    // TX fill, overrun, drain, underrun
    for (int i = 0; i < DEPTH; i++) tx_push(8'(i + 16));
    chk("R1 tx full status", {23'd0, fifo_status[8:0]}, 32'h090);
    clr(7'h7F);
    tx_push(8'hEE);
    chk("R3 tx overrun bit", {31'd0, int_status[3]}, 32'd1);
    chk("R3 tx level kept", {25'd0, fifo_status[6:0]}, 32'd16);
    ok = 1;
    for (int i = 0; i < DEPTH; i++) begin
      tx_pop();
      if (seq_tx_data != 8'(i + 16)) ok = 0;
    end
    chk("R3 tx contents unchanged", {31'd0, ok}, 32'd1);
    chk("R1 tx empty flag", {31'd0, fifo_status[8]}, 32'd1);
    tx_pop();
    chk("R4 tx underrun data", {24'd0, seq_tx_data}, 32'd0);
    chk("R4 tx underrun bit", {31'd0, int_status[2]}, 32'd1);

    // RX fill, overrun, drain, underrun
    for (int i = 0; i < DEPTH; i++) rx_push(8'(i + 64));
    clr(7'h7F);
    rx_push(8'hDD);
    chk("R3 rx overrun bit", {31'd0, int_status[5]}, 32'd1);
    chk("R2 rx full status", {23'd0, fifo_status[24:16]}, 32'h090);
    ok = 1;
    for (int i = 0; i < DEPTH; i++) begin
      rx_pop();
      if (host_rx_data != 8'(i + 64)) ok = 0;
    end
    chk("R3 rx contents unchanged", {31'd0, ok}, 32'd1);
    rx_pop();
    chk("R4 rx underrun data", {24'd0, host_rx_data}, 32'd0);
    chk("R4 rx underrun bit", {31'd0, int_status[4]}, 32'd1);

    // R6 transmit almost-empty
    tx_push(8'h01); tx_push(8'h02); tx_push(8'h03);
    clr(7'h7F);
    cyc();
    chk("R6 level 3 above trig", {31'd0, int_status[0]}, 32'd0);
    tx_pop();
    cyc();
    chk("R6 level 2 at trig", {31'd0, int_status[0]}, 32'd1);
    tx_pop(); tx_pop();

    // R7 receive almost-full
    rx_push(8'h11); rx_push(8'h12); rx_push(8'h13);
    clr(7'h7F);
    cyc();
    chk("R7 level 3 below trig", {31'd0, int_status[1]}, 32'd0);
    rx_push(8'h14);
    cyc();
    chk("R7 level 4 at trig", {31'd0, int_status[1]}, 32'd1);
    for (int i = 0; i < 4; i++) rx_pop();

    // R8 trailing timer, limit 3 -> fires on 4th quiet edge
    rx_push(8'h21);
    seq_rx_wr = 1; seq_rx_data = 8'h22; stat_clr_wr = 1; stat_clr_mask = 7'h7F;
    cyc();
    seq_rx_wr = 0; stat_clr_wr = 0;
    repeat (3) cyc();
    chk("R8 not yet after 3 quiet edges", {31'd0, int_status[6]}, 32'd0);
    cyc();
    chk("R8 fires after 4 quiet edges", {31'd0, int_status[6]}, 32'd1);
    host_rx_rd = 1; stat_clr_wr = 1; stat_clr_mask = 7'h40;
    cyc();
    host_rx_rd = 0; stat_clr_wr = 0;
    repeat (3) cyc();
    chk("R8 pop restarts count", {31'd0, int_status[6]}, 32'd0);
    cyc();
    chk("R8 fires again", {31'd0, int_status[6]}, 32'd1);
    rx_pop();

    // R9 write-1-to-clear
    tx_pop();
    clr(7'h04);
    chk("R9 cleared bit2 only", {30'd0, int_status[6], int_status[2]}, 32'd2);
    clr(7'h01);
    chk("R9 persistent bit0 stays", {31'd0, int_status[0]}, 32'd1);

    // R10 masking
    int_mask = 7'h40; cyc();
    chk("R10 enabled bit raises irq", {31'd0, irq}, 32'd1);
    int_mask = 7'h04; cyc();
    chk("R10 masked-in clear bit quiet", {31'd0, irq}, 32'd0);
    int_mask = 7'h00;

    // R5 disable
    tx_push(8'h31); tx_push(8'h32);
    ctrl_word = CTRL_TXOFF;
    cyc();
    clr(7'h0D);
    chk("R5 disabled tx flushed", {23'd0, fifo_status[8:0]}, 32'h100);
    tx_push(8'h33); tx_pop();
    cyc();
    chk("R5 disabled ignores access", {25'd0, fifo_status[6:0]}, 32'd0);
    chk("R5 no flags while disabled", {28'd0, int_status[3:2], 1'b0, int_status[0]}, 32'd0);
    ctrl_word = CTRL_ON;
    cyc();
    chk("R5 re-enabled empty", {23'd0, fifo_status[8:0]}, 32'h100);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule